// File: doc/BRIEF.md
# Dual-Axis Byte-Wide Register Port

This block lets an 8-bit host reach the 24-bit registers of two counter axes, X and Y, over a byte-wide bus. Each axis has a preset register that the host fills and an output latch that the host reads. Both are reached one byte at a time through a per-axis byte pointer that advances after every data access. The counters themselves sit outside the block. It sees them only through two count inputs and drives the preset values out on two preset outputs.

A bus cycle is qualified by chip select. A read or write strobe starts it, and a control/data input classifies it. The axis-select input picks X or Y. On a control write, data bits 7..5 form a command code. Bits 4..0 are ignored. Command 000 clears the selected axis's pointer. Command 001 copies the selected counter into its latch and clears that pointer. Command 011 does the same for both axes in one cycle, so the two snapshots are taken at the same moment.

A bus-cycle state machine turns each strobe, however long it is held, into exactly one access. It has three states. In `BUS_IDLE`, chip select with a write strobe performs the write and moves to `BUS_WRITE` (transition *write start*). Chip select with a read strobe and no write strobe moves to `BUS_READ` and records the axis and the cycle kind (transition *read start*). `BUS_WRITE` stays put while the write strobe and chip select are both held, then returns to `BUS_IDLE` (*write end*). `BUS_READ` stays put while the read strobe and chip select are both held. When either drops it returns to `BUS_IDLE` and advances the recorded axis's pointer if the read was a data read (*read end*). The write strobe wins if both strobes are asserted together.

Top module: `dual_axis_byte_port`

## Requirements
- R1: After reset both presets, both latches and both byte pointers are zero, and `dout` is zero.
- R2: A data write stores `din` into the preset byte selected by that axis's pointer (pointer 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16), one clock edge after the strobe is seen. The pointer advances exactly once per write cycle, however long the strobe is held.
- R3: The byte pointer wraps from 2 back to 0, so the fourth data access after a clear reaches bits 7:0 again.
- R4: Control code 001 (din[7:5]) loads the selected axis's latch from its count input and clears its pointer. Later changes on the count input leave the latch unchanged.
- R5: Control code 000 clears the selected axis's pointer and leaves its preset and latch unchanged.
- R6: Control code 011 loads both latches from their count inputs in the same cycle and clears both pointers, whatever the axis select.
- R7: Control codes 010, 100, 101, 110 and 111 change no pointer, latch or preset.
- R8: During a data read, `dout` shows the latch byte of the selected axis at its pointer. The pointer advances when the read cycle ends.
- R9: `dout` is zero unless chip select and read strobe are both high and control/data selects data (`ctl_sel`=0). A control read moves no pointer.
- R10: Strobes without chip select perform no access.
- R11: An access to one axis never moves the other axis's pointer or changes its registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Chip select, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| ctl_sel | input | 1 | 1 = control cycle, 0 = data cycle |
| axis_y | input | 1 | 0 = X axis, 1 = Y axis |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, zero when not reading data |
| x_count | input | 24 | Live X counter value |
| y_count | input | 24 | Live Y counter value |
| x_preset | output | 24 | X preset register |
| y_preset | output | 24 | Y preset register |

## Verification
A pointer that is wrong by one shows up at the ports on the very next data access. A write lands in the wrong preset byte, which is visible on the preset outputs one edge later. A read returns a byte that does not match its position in the captured value, which is visible on `dout` in the same cycle. A latch loaded at the wrong moment, or reloaded by an ignored code, shows up when its bytes are read back after the count inputs have moved on. The bench keeps an arithmetic model of the pointers, presets and latches and checks every byte that comes out. A single misstep therefore fails the next check after it.

// File: rtl/dabp_pkg.sv
package dabp_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_state_t;

    localparam logic [2:0] CMD_PTR_CLR     = 3'b000;
    localparam logic [2:0] CMD_CAPTURE     = 3'b001;
    localparam logic [2:0] CMD_CAPTURE_ALL = 3'b011;

endpackage

// File: rtl/dabp_bus_fsm.sv
module dabp_bus_fsm
    import dabp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd,
    input  logic wr,
    input  logic ctl,
    input  logic axis,
    output logic wr_evt,
    output logic rd_done,
    output logic ev_ctl,
    output logic ev_axis
);

    bus_state_t state_q, state_nx;
    logic       axis_q, ctl_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (sel && wr)      state_nx = BUS_WRITE;
                else if (sel && rd) state_nx = BUS_READ;
            end
            BUS_WRITE: if (!(sel && wr)) state_nx = BUS_IDLE;
            BUS_READ:  if (!(sel && rd)) state_nx = BUS_IDLE;
            default:   state_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            axis_q  <= 1'b0;
            ctl_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == BUS_IDLE && state_nx == BUS_READ) begin
                axis_q <= axis;
                ctl_q  <= ctl;
            end
        end
    end

    always_comb begin
        wr_evt  = (state_q == BUS_IDLE) && sel && wr;
        rd_done = (state_q == BUS_READ) && !(sel && rd);
        ev_axis = (state_q == BUS_READ) ? axis_q : axis;
        ev_ctl  = (state_q == BUS_READ) ? ctl_q : ctl;
    end

    // R10: without chip select an idle bus stays idle
    a_r10_idle_without_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && !sel) |=> (state_q == BUS_IDLE));

    // R2: one write event per write cycle
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt);

    // R8: a read cycle ends with exactly one completion
    a_r8_single_read_end: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (state_q == BUS_IDLE));

endmodule

// File: rtl/dabp_axis_regs.sv
module dabp_axis_regs #(
    parameter int DATA_W = 8,
    parameter int NBYTES = 3,
    localparam int CW    = DATA_W * NBYTES,
    localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_adv,
    input  logic              ptr_clr,
    input  logic              capture,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW-1:0]     count,
    output logic [CW-1:0]     preset,
    output logic [DATA_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    logic [NBYTES-1:0][DATA_W-1:0] preset_q, latch_q;
    logic [PTR_W-1:0]              ptr_q, ptr_inc;

    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_clr || capture) begin
            ptr_q <= '0;
        end else if (wr_en || rd_adv) begin
            ptr_q <= ptr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q <= '0;
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_en && ptr_q == PTR_W'(b)) preset_q[b] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latch_q <= '0;
        else if (capture) latch_q <= count;
    end

    assign preset = preset_q;
    assign ptr    = ptr_q;
    assign rdata  = (ptr_q <= LAST) ? latch_q[ptr_q] : '0;

    a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);

    a_r3_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_adv) && !ptr_clr && !capture && ptr_q == LAST) |=> (ptr_q == '0));

    a_r2_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_adv) && !ptr_clr && !capture && ptr_q != LAST)
        |=> (ptr_q == $past(ptr_q) + 1'b1));

    a_r5_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_clr || capture) |=> (ptr_q == '0));

    a_r4_latch_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (latch_q == $past(count)));

    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(latch_q));

    a_r8_preset_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(preset_q));

endmodule

// File: rtl/dual_axis_byte_port.sv
module dual_axis_byte_port
    import dabp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NBYTES = 3,
    localparam int CW    = DATA_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              ctl_sel,
    input  logic              axis_y,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic [CW-1:0]     x_count,
    input  logic [CW-1:0]     y_count,
    output logic [CW-1:0]     x_preset,
    output logic [CW-1:0]     y_preset
);

    localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int NAXES = 2;

    logic wr_evt, rd_done, ev_ctl, ev_axis;
    logic data_wr, ctl_wr, data_rd_end;
    logic [2:0] code;

    logic [CW-1:0]     cnt_a [NAXES];
    logic [CW-1:0]     pre_a [NAXES];
    logic [DATA_W-1:0] rd_a  [NAXES];
    logic [PTR_W-1:0]  ptr_a [NAXES];

    dabp_bus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .rd      (rd_stb),
        .wr      (wr_stb),
        .ctl     (ctl_sel),
        .axis    (axis_y),
        .wr_evt  (wr_evt),
        .rd_done (rd_done),
        .ev_ctl  (ev_ctl),
        .ev_axis (ev_axis)
    );

    assign data_wr     = wr_evt && !ev_ctl;
    assign ctl_wr      = wr_evt && ev_ctl;
    assign data_rd_end = rd_done && !ev_ctl;
    assign code        = din[DATA_W-1 -: 3];

    assign cnt_a[0] = x_count;
    assign cnt_a[1] = y_count;

    for (genvar a = 0; a < NAXES; a++) begin : g_axis
        logic is_me;
        assign is_me = (ev_axis == 1'(a));

        dabp_axis_regs #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (data_wr && is_me),
            .rd_adv  (data_rd_end && is_me),
            .ptr_clr (ctl_wr && is_me && code == CMD_PTR_CLR),
            .capture (ctl_wr && ((is_me && code == CMD_CAPTURE) || code == CMD_CAPTURE_ALL)),
            .wdata   (din),
            .count   (cnt_a[a]),
            .preset  (pre_a[a]),
            .rdata   (rd_a[a]),
            .ptr     (ptr_a[a])
        );
    end

    assign x_preset = pre_a[0];
    assign y_preset = pre_a[1];
    assign dout     = (bus_sel && rd_stb && !ctl_sel) ? rd_a[axis_y] : '0;

    // R9: bus output quiet outside a data read
    a_r9_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && rd_stb && !ctl_sel) |-> (dout == '0));

    // R11: a data access to X keeps the Y pointer
    a_r11_x_keeps_y: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_evt || rd_done) && !ev_ctl && !ev_axis) |=> $stable(ptr_a[1]));

    // R11: a data access to Y keeps the X pointer
    a_r11_y_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_evt || rd_done) && !ev_ctl && ev_axis) |=> $stable(ptr_a[0]));

endmodule

// File: tb/test_dual_axis_byte_port.sv
module test_dual_axis_byte_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, ctl_sel = 1'b0, axis_y = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [23:0] x_count = '0, y_count = '0;
    logic [23:0] x_preset, y_preset;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 1'b0;

    logic [23:0] exp_pre [2];
    logic [23:0] exp_lat [2];
    int          exp_ptr [2];

    dual_axis_byte_port i_dual_axis_byte_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .ctl_sel(ctl_sel), .axis_y(axis_y), .din(din), .dout(dout),
        .x_count(x_count), .y_count(y_count), .x_preset(x_preset), .y_preset(y_preset)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_presets(input string req);
        check(req, {8'h0, x_preset}, {8'h0, exp_pre[0]});
        check(req, {8'h0, y_preset}, {8'h0, exp_pre[1]});
    endtask

    // one write cycle; hold = cycles the strobe stays high
    task automatic bus_write(input bit ctl, input bit ax, input logic [7:0] d, input int hold);
        @(negedge clk);
        bus_sel = 1'b1; wr_stb = 1'b1; ctl_sel = ctl; axis_y = ax; din = d;
        repeat (hold) @(negedge clk);
        wr_stb = 1'b0; bus_sel = 1'b0;
        @(negedge clk);
        if (!ctl) begin
            exp_pre[ax][exp_ptr[ax]*8 +: 8] = d;
            exp_ptr[ax] = (exp_ptr[ax] + 1) % 3;
        end else begin
            case (d[7:5])
                3'b000: exp_ptr[ax] = 0;
                3'b001: begin exp_lat[ax] = ax ? y_count : x_count; exp_ptr[ax] = 0; end
                3'b011: begin
                    exp_lat[0] = x_count; exp_lat[1] = y_count;
                    exp_ptr[0] = 0; exp_ptr[1] = 0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic bus_read(input string req, input bit ctl, input bit ax);
        @(negedge clk);
        bus_sel = 1'b1; rd_stb = 1'b1; ctl_sel = ctl; axis_y = ax;
        #1;
        if (ctl) check(req, {24'h0, dout}, 32'h0);
        else     check(req, {24'h0, dout}, {24'h0, exp_lat[ax][exp_ptr[ax]*8 +: 8]});
        @(negedge clk);
        rd_stb = 1'b0; bus_sel = 1'b0;
        @(negedge clk);
        if (!ctl) exp_ptr[ax] = (exp_ptr[ax] + 1) % 3;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 2; a++) begin exp_pre[a] = '0; exp_lat[a] = '0; exp_ptr[a] = 0; end
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1", {24'h0, dout}, 32'h0);
        check_presets("R1");
        rst_n = 1'b1;
        bus_read("R1", 1'b0, 1'b0);
        bus_read("R1", 1'b0, 1'b1);
        bus_write(1'b1, 1'b0, 8'h00, 1);
        bus_write(1'b1, 1'b1, 8'h00, 1);

        // R2: preset fill sweep on both axes, varying strobe length
        for (int ax = 0; ax < 2; ax++) begin
            for (int t = 0; t < 4; t++) begin
                for (int k = 0; k < 3; k++) begin
                    bus_write(1'b0, ax[0], 8'((t * 53 + k * 29 + ax * 101 + 7) & 8'hFF), 1 + ((t + k) % 3));
                    check_presets("R2");
                end
            end
        end

        // R3: fourth write wraps to the low byte
        for (int k = 0; k < 4; k++) begin
            bus_write(1'b0, 1'b0, 8'hA0 + 8'(k), 1);
            check_presets("R3");
        end

        // R5: pointer clear, preset and latch untouched
        bus_write(1'b1, 1'b0, 8'h1F, 1);
        check_presets("R5");
        bus_write(1'b0, 1'b0, 8'h55, 1);
        check_presets("R5");
        bus_read("R5", 1'b0, 1'b0);

        // R4 / R8: capture then read all bytes after the count has moved
        for (int t = 0; t < 4; t++) begin
            x_count = 24'(t * 24'h3A51C7 + 24'h0BCDEF);
            bus_write(1'b1, 1'b0, 8'h20 | 8'(t), 1);
            x_count = ~x_count;
            for (int k = 0; k < 4; k++) bus_read("R4", 1'b0, 1'b0);
        end
        for (int k = 0; k < 3; k++) bus_read("R8", 1'b0, 1'b0);

        // R7: ignored codes
        x_count = 24'h777777;
        y_count = 24'h999999;
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c == 1 || c == 3) continue;
            bus_write(1'b1, 1'b0, 8'(c << 5) | 8'h15, 1);
            bus_write(1'b1, 1'b1, 8'(c << 5) | 8'h0A, 1);
            check_presets("R7");
            bus_read("R7", 1'b0, 1'b0);
            bus_read("R7", 1'b0, 1'b1);
        end

        // R6: joint capture issued with Y selected
        x_count = 24'h13579B;
        y_count = 24'h2468AC;
        bus_write(1'b1, 1'b1, 8'h60, 1);
        x_count = 24'h0;
        y_count = 24'h0;
        for (int k = 0; k < 3; k++) begin
            bus_read("R6", 1'b0, 1'b1);
            bus_read("R6", 1'b0, 1'b0);
        end

        // R9: control read returns zero and moves no pointer
        bus_read("R9", 1'b1, 1'b0);
        bus_read("R9", 1'b0, 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; ctl_sel = 1'b0;
        #1 check("R9", {24'h0, dout}, 32'h0);
        bus_sel = 1'b0;

        // R10: strobes without chip select
        @(negedge clk);
        wr_stb = 1'b1; ctl_sel = 1'b0; axis_y = 1'b0; din = 8'hEE;
        @(negedge clk);
        ctl_sel = 1'b1; din = 8'h60;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b1; ctl_sel = 1'b0;
        #1 check("R10", {24'h0, dout}, 32'h0);
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
        check_presets("R10");
        bus_read("R10", 1'b0, 1'b0);

        // R11: X traffic leaves Y pointer and preset alone
        bus_write(1'b1, 1'b1, 8'h00, 1);
        for (int k = 0; k < 5; k++) begin
            bus_write(1'b0, 1'b0, 8'hC0 + 8'(k), 1);
            bus_read("R11", 1'b0, 1'b0);
        end
        check_presets("R11");
        bus_read("R11", 1'b0, 1'b1);
        bus_write(1'b0, 1'b1, 8'h3C, 1);
        check_presets("R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule